// File: doc/BRIEF.md
# Configurable Pin Trigger Detector

This block watches a bank of general-purpose input pins and turns clean transitions on selected pins into trigger events. Every pin has a two-bit mode field that makes it a plain input, an alternate-function pin, a trigger on falling edges only, or a trigger on both edges. Only the two trigger modes can produce events; the other two leave the pin to other logic.

Each pin passes through a two-flop synchronizer and a debouncer. The debouncer accepts a new level only after the synchronized input has differed from the accepted level for a fixed number of consecutive clocks. One shared control input chooses between a long qualification time and a short, near-immediate one. When a qualifying edge appears, the block emits a one-cycle event with the pin index, sets a sticky interrupt flag, and, while the power-down input is high, raises a wake pulse. Edge detection keeps running in power-down. The reference level for each pin is the accepted level it held when power-down was entered, and it changes only when the accepted level itself changes.

Top module: `gpio_trig_detect`

## Requirements
- R1: After reset, trig_o, trig_idx_o, irq_o and wake_o are all 0. The accepted level of every pin starts at 1 (idle high).
- R2: Pin i's mode is mode_i[2i+1:2i]. Code 00 (plain input) and code 01 (alternate function) never produce an event on either edge.
- R3: Code 10 produces an event on an accepted 1-to-0 transition of the pin only. A 0-to-1 transition produces none.
- R4: Code 11 produces an event on every accepted transition of the pin, falling or rising.
- R5: With fast_deb_i low, a pin that changes before clock edge 1 and then holds produces trig_o high after clock edge SLOW_DEB_CYC+3 and not before.
- R6: With fast_deb_i high, the same timing holds with FAST_DEB_CYC in place of SLOW_DEB_CYC.
- R7: A change that lasts fewer cycles than the selected qualification time produces no event. The qualification count restarts from zero whenever the input returns to the accepted level.
- R8: Each qualifying edge gives trig_o high for exactly one cycle, with trig_idx_o holding the 3-bit index of the pin.
- R9: When several pins qualify in the same cycle, one pulse is emitted and it carries the lowest index.
- R10: irq_o is set by every event and stays set until irq_clr_i is high at a clock edge. An event at that same edge keeps it set.
- R11: wake_o pulses together with trig_o only when pwr_down_i was high at the edge where the event was registered. Otherwise it stays 0.
- R12: While powered down, edges are still detected against the level held at power-down entry. In falling-only mode, a pin that was low at entry and then rises gives no event, and its next fall gives an event and a wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Raw pin levels |
| mode_i | input | 2*NUM_PINS | Per-pin mode codes, two bits each |
| fast_deb_i | input | 1 | 1 selects the short qualification time |
| pwr_down_i | input | 1 | Device is in the powered-down state |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| trig_o | output | 1 | One-cycle trigger event |
| trig_idx_o | output | 3 | Index of the triggering pin |
| irq_o | output | 1 | Sticky interrupt flag |
| wake_o | output | 1 | Wake request pulse |

## Verification
The hardest case to reach from the ports is two pins qualifying in exactly the same cycle. The bench drives both pins at the same negative clock edge with the same mode and debounce setting, so their synchronizers and counters run in lockstep. It then counts the pulses over a window that covers both pins' qualification times. Power-down behaviour is checked by entering power-down with a pin already low and then sending a rising edge and a falling edge. Only the fall may wake the device.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;

  typedef enum logic [1:0] {
    PM_PLAIN = 2'b00,
    PM_ALT   = 2'b01,
    PM_FALL  = 2'b10,
    PM_BOTH  = 2'b11
  } pin_mode_e;

endpackage

// File: rtl/gpio_deb_cell.sv
module gpio_deb_cell #(
  parameter int SLOW_DEB_CYC = 4000000,
  parameter int FAST_DEB_CYC = 2,
  parameter bit IDLE_LVL     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fast_i,
  output logic lvl_o
);
  localparam int MAXC = (SLOW_DEB_CYC > FAST_DEB_CYC) ? SLOW_DEB_CYC : FAST_DEB_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DEB_CYC - 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DEB_CYC - 1);

  logic          sync1_q, sync2_q;
  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim;
  logic          differs;
  logic          done;

  always_comb begin
    lim     = fast_i ? FAST_LIM : SLOW_LIM;
    differs = (sync2_q != lvl_q);
    done    = differs && (cnt_q >= lim);
    lvl_d   = lvl_q;
    cnt_d   = '0;
    if (done) begin
      lvl_d = sync2_q;
    end else if (differs) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= IDLE_LVL;
      sync2_q <= IDLE_LVL;
      lvl_q   <= IDLE_LVL;
      cnt_q   <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      lvl_q   <= lvl_d;
      cnt_q   <= cnt_d;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/gpio_edge_qual.sv
module gpio_edge_qual
  import gpio_trig_pkg::*;
#(
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  output logic       ev_o
);
  logic      ref_q;
  logic      fell, rose;
  pin_mode_e mode;

  always_comb begin
    mode = pin_mode_e'(mode_i);
    fell = ref_q & ~lvl_i;
    rose = ~ref_q & lvl_i;
    unique case (mode)
      PM_FALL: ev_o = fell;
      PM_BOTH: ev_o = fell | rose;
      default: ev_o = 1'b0;
    endcase
  end

  // The reference changes only with the accepted level, so on entry to
  // power-down it already holds the entry level and keeps it until the
  // accepted level next changes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= IDLE_LVL;
    else        ref_q <= lvl_i;
  end
endmodule

// File: rtl/gpio_trig_arb.sv
module gpio_trig_arb #(
  parameter int NUM_PINS = 6,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] ev_i,
  input  logic                pwr_down_i,
  input  logic                irq_clr_i,
  output logic                trig_o,
  output logic [IDX_W-1:0]    trig_idx_o,
  output logic                irq_o,
  output logic                wake_o
);
  logic             any_ev;
  logic [IDX_W-1:0] win_idx;
  logic             trig_q, irq_q, wake_q;
  logic             irq_d;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    any_ev  = |ev_i;
    win_idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (ev_i[i]) win_idx = IDX_W'(i);
    end
    irq_d = any_ev | (irq_q & ~irq_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      idx_q  <= '0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      trig_q <= any_ev;
      wake_q <= any_ev & pwr_down_i;
      irq_q  <= irq_d;
      if (any_ev) idx_q <= win_idx;
    end
  end

  assign trig_o     = trig_q;
  assign trig_idx_o = idx_q;
  assign irq_o      = irq_q;
  assign wake_o     = wake_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int NUM_PINS     = 6,
  parameter int SLOW_DEB_CYC = 4000000,
  parameter int FAST_DEB_CYC = 2,
  parameter bit IDLE_LVL     = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [2*NUM_PINS-1:0] mode_i,
  input  logic                  fast_deb_i,
  input  logic                  pwr_down_i,
  input  logic                  irq_clr_i,
  output logic                  trig_o,
  output logic [2:0]            trig_idx_o,
  output logic                  irq_o,
  output logic                  wake_o
);
  logic [NUM_PINS-1:0] lvl;
  logic [NUM_PINS-1:0] ev;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    gpio_deb_cell #(
      .SLOW_DEB_CYC(SLOW_DEB_CYC),
      .FAST_DEB_CYC(FAST_DEB_CYC),
      .IDLE_LVL    (IDLE_LVL)
    ) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_i[g]),
      .fast_i(fast_deb_i),
      .lvl_o (lvl[g])
    );

    gpio_edge_qual #(
      .IDLE_LVL(IDLE_LVL)
    ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (lvl[g]),
      .mode_i(mode_i[2*g +: 2]),
      .ev_o  (ev[g])
    );
  end

  gpio_trig_arb #(
    .NUM_PINS(NUM_PINS),
    .IDX_W   (3)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_i      (ev),
    .pwr_down_i(pwr_down_i),
    .irq_clr_i (irq_clr_i),
    .trig_o    (trig_o),
    .trig_idx_o(trig_idx_o),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
  );
endmodule

// File: rtl/gpio_trig_chk.sv
module gpio_trig_chk #(
  parameter int NUM_PINS = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2*NUM_PINS-1:0] mode_i,
  input logic                  pwr_down_i,
  input logic                  irq_clr_i,
  input logic                  trig_o,
  input logic [2:0]            trig_idx_o,
  input logic                  irq_o,
  input logic                  wake_o
);
  logic [2*NUM_PINS-1:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_i;
  end

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (int'(trig_idx_o) < NUM_PINS));

  // R2: an event only comes from a pin whose mode had the trigger bit set
  assert_trig_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> mode_q[2*int'(trig_idx_o) + 1]);

  assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> irq_o);

  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !trig_o) |-> ($past(irq_o) && !$past(irq_clr_i)));

  assert_wake_pd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (trig_o && $past(pwr_down_i)));
endmodule

bind gpio_trig_detect gpio_trig_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .pwr_down_i(pwr_down_i),
  .irq_clr_i (irq_clr_i),
  .trig_o    (trig_o),
  .trig_idx_o(trig_idx_o),
  .irq_o     (irq_o),
  .wake_o    (wake_o)
);

// File: tb/tb_gpio_trig_detect.sv
`timescale 1ns/1ps
module tb_gpio_trig_detect;
  localparam int NP   = 6;
  localparam int SLOW = 12;
  localparam int FAST = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin;
  logic [2*NP-1:0] mode;
  logic          fast_deb, pwr_down, irq_clr;
  logic          trig_o, irq_o, wake_o;
  logic [2:0]    trig_idx_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_trig_detect #(
    .NUM_PINS(NP), .SLOW_DEB_CYC(SLOW), .FAST_DEB_CYC(FAST), .IDLE_LVL(1'b1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .mode_i(mode),
    .fast_deb_i(fast_deb), .pwr_down_i(pwr_down), .irq_clr_i(irq_clr),
    .trig_o(trig_o), .trig_idx_o(trig_idx_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(input int p, input logic [1:0] m);
    mode[2*p +: 2] = m;
  endtask

  // Drive a pin at a falling clock edge, then watch n rising edges.
  task automatic drive_watch(input int p, input logic v, input int n,
                             output int first, output int cnt,
                             output int idx, output int wk);
    @(negedge clk);
    pin[p] = v;
    first = -1; cnt = 0; idx = -1; wk = 0;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); #1;
      if (trig_o) begin
        cnt++;
        if (first < 0) begin
          first = i; idx = int'(trig_idx_o); wk = int'(wake_o);
        end
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pin = '1; mode = '0; fast_deb = 1'b0;
    pwr_down = 1'b0; irq_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!trig_o && !irq_o && !wake_o && trig_idx_o == 3'd0, "R1 reset outputs",
        {trig_o, irq_o, wake_o, trig_idx_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (SLOW + 6) @(posedge clk);
    #1;
    chk(!trig_o && !irq_o, "R1 idle-high after reset", {trig_o, irq_o}, 0);
  endtask

  task automatic t_non_trigger;
    int f, c, x, w;
    set_mode(0, 2'b00); set_mode(1, 2'b01);
    drive_watch(0, 1'b0, SLOW + 10, f, c, x, w);
    chk(c == 0, "R2 mode 00 fall", c, 0);
    drive_watch(0, 1'b1, SLOW + 10, f, c, x, w);
    chk(c == 0, "R2 mode 00 rise", c, 0);
    drive_watch(1, 1'b0, SLOW + 10, f, c, x, w);
    chk(c == 0, "R2 mode 01 fall", c, 0);
    drive_watch(1, 1'b1, SLOW + 10, f, c, x, w);
    chk(c == 0, "R2 mode 01 rise", c, 0);
    chk(!irq_o, "R2 no irq", irq_o, 0);
  endtask

  task automatic t_falling;
    int f, c, x, w;
    set_mode(2, 2'b10);
    drive_watch(2, 1'b0, SLOW + 10, f, c, x, w);
    chk(f == SLOW + 3, "R5 slow qualification cycle", f, SLOW + 3);
    chk(c == 1, "R8 one pulse", c, 1);
    chk(x == 2, "R8 index", x, 2);
    chk(w == 0, "R11 no wake when powered up", w, 0);
    drive_watch(2, 1'b1, SLOW + 10, f, c, x, w);
    chk(c == 0, "R3 rise ignored in fall mode", c, 0);
  endtask

  task automatic t_both;
    int f, c, x, w;
    set_mode(3, 2'b11);
    drive_watch(3, 1'b0, SLOW + 10, f, c, x, w);
    chk(c == 1 && x == 3, "R4 fall event", x, 3);
    drive_watch(3, 1'b1, SLOW + 10, f, c, x, w);
    chk(c == 1 && x == 3, "R4 rise event", x, 3);
  endtask

  task automatic t_fast;
    int f, c, x, w;
    fast_deb = 1'b1;
    set_mode(5, 2'b10);
    drive_watch(5, 1'b0, SLOW + 10, f, c, x, w);
    chk(f == FAST + 3, "R6 fast qualification cycle", f, FAST + 3);
    chk(x == 5, "R6 index", x, 5);
    drive_watch(5, 1'b1, 10, f, c, x, w);
    fast_deb = 1'b0;
  endtask

  task automatic t_glitch;
    int f, c, x, w;
    set_mode(2, 2'b10);
    // low for SLOW-4 cycles, high, low again: count restarts
    drive_watch(2, 1'b0, SLOW - 4, f, c, x, w);
    chk(c == 0, "R7 short glitch", c, 0);
    drive_watch(2, 1'b1, 3, f, c, x, w);
    chk(c == 0, "R7 back high", c, 0);
    drive_watch(2, 1'b0, SLOW + 10, f, c, x, w);
    chk(f == SLOW + 3, "R7 count restarted", f, SLOW + 3);
    drive_watch(2, 1'b1, SLOW + 10, f, c, x, w);
  endtask

  task automatic t_priority;
    int c, first, idx;
    set_mode(1, 2'b10); set_mode(4, 2'b10);
    @(negedge clk);
    pin[1] = 1'b0; pin[4] = 1'b0;
    c = 0; first = -1; idx = -1;
    for (int i = 1; i <= SLOW + 10; i++) begin
      @(posedge clk); #1;
      if (trig_o) begin
        c++;
        if (first < 0) begin first = i; idx = int'(trig_idx_o); end
      end
    end
    chk(c == 1, "R9 single pulse", c, 1);
    chk(idx == 1, "R9 lowest index", idx, 1);
    @(negedge clk); pin[1] = 1'b1; pin[4] = 1'b1;
    repeat (SLOW + 6) @(posedge clk);
  endtask

  task automatic t_irq;
    @(negedge clk); #0;
    chk(irq_o, "R10 irq sticky", irq_o, 1);
    repeat (5) @(posedge clk);
    #1;
    chk(irq_o, "R10 irq held", irq_o, 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(!irq_o, "R10 irq cleared", irq_o, 0);
  endtask

  task automatic t_power_down;
    int f, c, x, w;
    set_mode(2, 2'b10);
    drive_watch(2, 1'b0, SLOW + 10, f, c, x, w);
    @(negedge clk); pwr_down = 1'b1;
    drive_watch(2, 1'b1, SLOW + 10, f, c, x, w);
    chk(c == 0, "R12 rise after low entry ignored", c, 0);
    drive_watch(2, 1'b0, SLOW + 10, f, c, x, w);
    chk(c == 1 && x == 2, "R12 fall in power-down", x, 2);
    chk(w == 1, "R11 wake in power-down", w, 1);
    @(negedge clk); pwr_down = 1'b0;
  endtask

  initial begin
    t_reset();
    t_non_trigger();
    t_falling();
    t_both();
    t_fast();
    t_glitch();
    t_priority();
    t_irq();
    t_power_down();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule